// File: doc/BRIEF.md
# Unaligned Burst Write Strobe Generator

This block produces the byte-lane enables for one incrementing write burst on a 32-bit data path. The start address may fall anywhere inside a word. The request gives a start address and a total byte count. A one-cycle start pulse launches the burst. The block then presents one beat at a time with a valid flag and waits for the receiver's ready. On every accepted beat it moves to the next beat's strobe, and it marks the final beat with a last flag.

The first beat enables only the lanes at or above the address offset. Every beat in the middle enables all lanes. The final beat enables only the low lanes that hold the remaining bytes. A burst that starts and ends inside one word enables only the lanes from the start offset to the end offset. The union of the lanes enabled across the burst is exactly the requested byte range. The data bytes, the address channel and the write response belong to other blocks.

Top module: `wstrb_gen`

## Requirements
- R1: After a synchronous reset, w_valid, w_last and w_strb are all zero.
- R2: A start pulse is accepted when w_valid is low and byte_count is non-zero. w_valid then rises on the next cycle.
- R3: On the first beat, strobe bit i (bit i enables byte lane i, lane 0 is the lowest address) is set only for lanes i >= start_addr[1:0]. For address 0x01 the first-beat strobe is 4'b1110.
- R4: Every beat that is neither the first nor the last has w_strb equal to 4'b1111.
- R5: On the final beat of a multi-beat burst, strobe bit i is set only for lanes i <= (start_addr[1:0] + byte_count - 1) mod 4. For 16 bytes from 0x01 this is 4'b0001.
- R6: The burst has floor((start_addr[1:0] + byte_count - 1) / 4) + 1 beats. For 16 bytes this gives five beats from 0x01 and four beats from 0x00.
- R7: w_last is high only on the final beat, and only while w_valid is high.
- R8: While w_valid is high and w_ready is low, w_valid, w_strb and w_last keep their values on the next cycle.
- R9: For a single-beat burst, strobe bit i is set only for lanes between start_addr[1:0] and start_addr[1:0] + byte_count - 1, inclusive.
- R10: A start pulse has no effect when it arrives while w_valid is high or when byte_count is zero.
- R11: The strobe bits summed over all accepted beats equal byte_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a burst |
| start_addr | input | 32 | Byte address of the first byte |
| byte_count | input | 12 | Total number of bytes to write |
| w_ready | input | 1 | Receiver accepts the current beat |
| w_valid | output | 1 | A beat is presented |
| w_strb | output | 4 | Byte-lane enables for the current beat |
| w_last | output | 1 | Current beat is the final one |

## Verification
All outputs come from registers. The first beat therefore appears one cycle after the clock edge that samples the start pulse. Each later beat appears one cycle after the edge on which both w_valid and w_ready were high. After the final handshake, w_valid drops on the next cycle. The bench drives inputs and samples outputs on the falling edge, halfway between rising edges. It compares each sample against the beat expected for the number of handshakes counted so far, so stalled cycles must repeat the same expected beat. Expected strobes come from the byte range [start, start + count): a lane is enabled when the byte address it covers on that beat falls inside the range.

// File: rtl/wstrb_pkg.sv
package wstrb_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_LEN_W  = 12;

  function automatic int unsigned offset_bits(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/wstrb_lane_mask.sv
module wstrb_lane_mask #(
  parameter int unsigned LANES = 4,
  parameter int unsigned OFF_W = 2
) (
  input  logic [OFF_W-1:0] lo,
  input  logic [OFF_W-1:0] hi,
  output logic [LANES-1:0] mask
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask[i] = (OFF_W'(i) >= lo) && (OFF_W'(i) <= hi);
  end
endmodule

// File: rtl/wstrb_plan.sv
module wstrb_plan #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned BEAT_W = LEN_W + 1
) (
  input  logic [OFF_W-1:0]  offset,
  input  logic [LEN_W-1:0]  count,
  output logic [LANES-1:0]  first_mask,
  output logic [LANES-1:0]  final_mask,
  output logic [BEAT_W-1:0] beats,
  output logic              single
);
  localparam int unsigned SPAN_W = LEN_W + 1;

  logic [SPAN_W-1:0] end_idx;
  logic [OFF_W-1:0]  end_lane;
  logic [LANES-1:0]  head_mask;

  // Index of the final byte counted from lane 0 of the first word.
  assign end_idx  = SPAN_W'(offset) + SPAN_W'(count) - SPAN_W'(1);
  assign end_lane = end_idx[OFF_W-1:0];
  assign beats    = BEAT_W'(end_idx >> OFF_W) + BEAT_W'(1);
  assign single   = (beats == BEAT_W'(1));

  wstrb_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_head (
    .lo  (offset),
    .hi  (OFF_W'(LANES - 1)),
    .mask(head_mask)
  );

  wstrb_lane_mask #(.LANES(LANES), .OFF_W(OFF_W)) u_tail (
    .lo  ('0),
    .hi  (end_lane),
    .mask(final_mask)
  );

  assign first_mask = single ? (head_mask & final_mask) : head_mask;
endmodule

// File: rtl/wstrb_seq.sv
module wstrb_seq #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BEAT_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [LANES-1:0]  first_mask,
  input  logic [LANES-1:0]  final_mask,
  input  logic [BEAT_W-1:0] beats,
  input  logic              single,
  input  logic              ready,
  output logic              valid,
  output logic [LANES-1:0]  strb,
  output logic              last
);
  logic [BEAT_W-1:0] remain_q;
  logic [LANES-1:0]  tail_q;
  logic              to_last;

  assign to_last = (remain_q == BEAT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      strb     <= '0;
      last     <= 1'b0;
      remain_q <= '0;
      tail_q   <= '0;
    end else if (!valid) begin
      if (launch) begin
        valid    <= 1'b1;
        strb     <= first_mask;
        last     <= single;
        remain_q <= beats - BEAT_W'(1);
        tail_q   <= final_mask;
      end
    end else if (ready) begin
      if (last) begin
        valid <= 1'b0;
        strb  <= '0;
        last  <= 1'b0;
      end else begin
        remain_q <= remain_q - BEAT_W'(1);
        last     <= to_last;
        strb     <= to_last ? tail_q : '1;
      end
    end
  end
endmodule

// File: rtl/wstrb_gen.sv
module wstrb_gen #(
  parameter int unsigned LANES  = wstrb_pkg::DEF_LANES,
  parameter int unsigned ADDR_W = wstrb_pkg::DEF_ADDR_W,
  parameter int unsigned LEN_W  = wstrb_pkg::DEF_LEN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  byte_count,
  input  logic              w_ready,
  output logic              w_valid,
  output logic [LANES-1:0]  w_strb,
  output logic              w_last
);
  localparam int unsigned OFF_W  = wstrb_pkg::offset_bits(LANES);
  localparam int unsigned BEAT_W = LEN_W + 1;

  logic [LANES-1:0]  first_mask;
  logic [LANES-1:0]  final_mask;
  logic [BEAT_W-1:0] beats;
  logic              single;
  logic              launch;

  assign launch = start && (byte_count != '0);

  wstrb_plan #(
    .LANES(LANES), .OFF_W(OFF_W), .LEN_W(LEN_W), .BEAT_W(BEAT_W)
  ) u_plan (
    .offset    (start_addr[OFF_W-1:0]),
    .count     (byte_count),
    .first_mask(first_mask),
    .final_mask(final_mask),
    .beats     (beats),
    .single    (single)
  );

  wstrb_seq #(.LANES(LANES), .BEAT_W(BEAT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .first_mask(first_mask),
    .final_mask(final_mask),
    .beats     (beats),
    .single    (single),
    .ready     (w_ready),
    .valid     (w_valid),
    .strb      (w_strb),
    .last      (w_last)
  );
endmodule

// File: rtl/wstrb_gen_chk.sv
module wstrb_gen_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] start_addr,
  input logic [LEN_W-1:0]  byte_count,
  input logic              w_ready,
  input logic              w_valid,
  input logic [LANES-1:0]  w_strb,
  input logic              w_last
);
  localparam int unsigned OFF_W = wstrb_pkg::offset_bits(LANES);

  logic             on_first;
  logic [LANES-1:0] below_off;
  logic [LANES-1:0] below_q;

  always_comb begin
    below_off = '0;
    for (int i = 0; i < LANES; i++)
      below_off[i] = (i < int'(start_addr[OFF_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_first <= 1'b0;
      below_q  <= '0;
    end else if (!w_valid && start && byte_count != '0) begin
      on_first <= 1'b1;
      below_q  <= below_off;
    end else if (w_valid && w_ready) begin
      on_first <= 1'b0;
    end
  end

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (!w_valid && start && byte_count != '0) |=> w_valid);

  // R3
  head_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && on_first) |-> ((w_strb & below_q) == '0));

  // R4
  middle_full_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !on_first && !w_last) |-> (w_strb == '1));

  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    w_last |-> w_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_strb) && $stable(w_last)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready && start) |=> $stable(w_strb));
endmodule

bind wstrb_gen wstrb_gen_chk #(
  .LANES(LANES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
  .byte_count(byte_count), .w_ready(w_ready), .w_valid(w_valid),
  .w_strb(w_strb), .w_last(w_last)
);

// File: tb/wstrb_gen_test.sv
module wstrb_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [11:0] byte_count = '0;
  logic        w_ready = 1'b0;
  logic        w_valid;
  logic [3:0]  w_strb;
  logic        w_last;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wstrb_gen uut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .byte_count(byte_count), .w_ready(w_ready), .w_valid(w_valid),
    .w_strb(w_strb), .w_last(w_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lane l on beat b is enabled when its byte address lies inside the range.
  function automatic logic [3:0] exp_strb(input int addr, input int cnt, input int b);
    logic [3:0] m;
    int base;
    base = (addr / 4) * 4 + 4 * b;
    for (int l = 0; l < 4; l++)
      m[l] = (base + l >= addr) && (base + l < addr + cnt);
    return m;
  endfunction

  // stall bit k set: w_ready low on sampled cycle k. inject: start while busy.
  task automatic run_burst(input int addr, input int cnt, input int exp_beats,
                           input logic [31:0] stall, input bit inject, input string tag);
    int beat = 0;
    int cyc = 0;
    int bits = 0;
    bit first_bad = 0;
    bit mid_bad = 0;
    bit last_bad = 0;
    @(negedge clk);
    start = 1'b1; start_addr = addr; byte_count = 12'(cnt);
    @(negedge clk);
    start = 1'b0;
    check(w_valid === 1'b1, {"R2 ", tag}, int'(w_valid), 1);
    while (w_valid === 1'b1 && cyc < 300) begin
      logic [3:0] e;
      e = exp_strb(addr, cnt, beat);
      if (beat == 0 && w_strb !== e) first_bad = 1;
      if (beat > 0 && beat < exp_beats - 1 && w_strb !== e) mid_bad = 1;
      if (beat == exp_beats - 1 && beat > 0 && w_strb !== e) last_bad = 1;
      if (w_strb !== e || w_last !== (beat == exp_beats - 1))
        check(0, {"R7/R8 beat ", tag}, int'({w_last, w_strb}),
              int'({beat == exp_beats - 1, e}));
      w_ready = ~stall[cyc % 32];
      if (inject && cyc == 1) begin
        start = 1'b1; start_addr = 32'h2; byte_count = 12'd3;
      end else begin
        start = 1'b0;
      end
      if (w_ready) bits += $countones(w_strb);
      cyc++;
      @(negedge clk);
      if (w_ready) beat++;
    end
    start = 1'b0; w_ready = 1'b0;
    if (exp_beats == 1) check(!first_bad, {"R9 ", tag}, beat, exp_beats);
    else begin
      check(!first_bad, {"R3 ", tag}, beat, exp_beats);
      check(!last_bad, {"R5 ", tag}, beat, exp_beats);
      if (exp_beats > 2) check(!mid_bad, {"R4 ", tag}, beat, exp_beats);
    end
    check(beat == exp_beats, {"R6 ", tag}, beat, exp_beats);
    check(bits == cnt, {"R11 ", tag}, bits, cnt);
    @(negedge clk);
    check(w_valid === 1'b0, {"R10 idle after ", tag}, int'(w_valid), 0);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(w_valid === 1'b0 && w_last === 1'b0 && w_strb === 4'b0, "R1 reset",
          int'({w_valid, w_last, w_strb}), 0);
    rst = 1'b0;
  endtask

  task automatic test_zero_count;
    @(negedge clk);
    start = 1'b1; start_addr = 32'h5; byte_count = 12'd0;
    @(negedge clk);
    start = 1'b0;
    check(w_valid === 1'b0 && w_strb === 4'b0, "R10 zero count",
          int'({w_valid, w_strb}), 0);
  endtask

  task automatic test_first_strobe_0x01;
    @(negedge clk);
    start = 1'b1; start_addr = 32'h1; byte_count = 12'd16;
    @(negedge clk);
    start = 1'b0;
    check(w_strb === 4'b1110, "R3 first strobe 0x01", int'(w_strb), 4'he);
    w_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(w_strb === 4'b0001 && w_last === 1'b1, "R5 last strobe 0x01",
          int'({w_last, w_strb}), 5'h11);
    @(negedge clk);
    w_ready = 1'b0;
    check(w_valid === 1'b0, "R7 done 0x01", int'(w_valid), 0);
  endtask

  initial begin
    test_reset();
    test_zero_count();
    test_first_strobe_0x01();
    run_burst(32'h1, 16, 5, 32'h0, 0, "a01_n16");
    run_burst(32'h0, 16, 4, 32'h0, 0, "a00_n16");
    run_burst(32'h1, 2, 1, 32'h0, 0, "a01_n2");
    run_burst(32'h3, 1, 1, 32'h1, 0, "a03_n1");
    run_burst(32'h102, 13, 4, 32'h0000_0a5b, 0, "stall");
    run_burst(32'h7, 9, 3, 32'h0000_0006, 1, "busy_start");
    run_burst(32'h2, 4, 2, 32'h0, 0, "a02_n4");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule